// File: doc/BRIEF.md
# Serial TDM Receiver with Quarter-Bit Input Delay

This block takes one serial time-division-multiplexed input line and turns it into channel bytes. It runs on a system clock of sixteen cycles per bit and takes its alignment from a frame pulse. Each frame holds 128 channels of eight bits. The first bit of each channel is its most significant bit. For each channel, the block presents the byte on its output together with the channel index and a one-cycle valid strobe.

The point where the line is sampled can be moved later than the frame boundary in steps of a quarter bit, up to seven and three-quarter bits. This lets a board with a skewed line still be received correctly. With large settings, the bits of channel 127 arrive after the next frame pulse. They are still delivered under index 127. A new delay setting takes effect only at the next frame pulse, so the frame in progress is not broken up.

Top module: `tdm_frac_delay_rx`

## Requirements
- R1: While reset is asserted and right after it, valid_o is 0 and byte_o and chan_o are 0. The active delay resets to 0.
- R2: valid_o stays 0 until the first frame pulse has been received, whatever the state of ser_i.
- R3: The frame pulse is sampled high at a clock edge, and the cycle after that edge is cycle 0 of the frame. Frame bit b covers cycles 16b to 16b+15. With a delay of 0, each bit is sampled at the clock edge that ends cycle 16b+12.
- R4: delay_i counts quarter bits, from 0 to 31. Each step moves the sampling edge 4 cycles later. Channel c is reported with valid_o high in cycle (16·(8c+7) + 12 + 4·d + 1) mod 16384, where d is the active delay.
- R5: byte_o holds the eight samples of one channel, with the first-received sample in bit 7 and the last in bit 0.
- R6: Channel indices on chan_o run 0, 1, … 127 and then wrap to 0. chan_o changes only while valid_o is high.
- R7: valid_o is never high in two consecutive cycles.
- R8: When the delay pushes the sampling of channel 127 past the next frame pulse, its byte is still assembled from that earlier frame's bits. It is reported with index 127 early in the new frame.
- R9: The delay is taken from delay_i only at the clock edge where frame_i is high. A change to delay_i at any other time has no effect on the timing until that next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 16 cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse, one cycle wide, marks the start of a frame |
| ser_i | input | 1 | Serial TDM data line |
| delay_i | input | 5 | Input delay in quarter bits (0..31) |
| byte_o | output | 8 | Assembled channel byte |
| chan_o | output | 7 | Index of the channel on byte_o |
| valid_o | output | 1 | One-cycle strobe for byte_o and chan_o |

## Verification
A wrong frame position or a wrong latched delay moves every valid strobe away from its expected cycle. Within the first channel of a frame, roughly 130 to 250 cycles after the pulse, chan_o, byte_o and the strobe timing all disagree with the bench's prediction. A slip in the bit counter within a channel shows up as rotated bytes at the next strobe. A fault in the wrap arithmetic only appears on the straddling channel 127, in the early cycles of the next frame. The bench therefore runs several frames with large delays, and these bytes are checked on their own.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned CLK_PER_BIT = 16;
  localparam int unsigned BITS_PER_CH = 8;
  localparam int unsigned NUM_CH      = 128;
  localparam int unsigned DLY_W       = 5;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned FRAME_LEN = 16384,
  parameter int unsigned POS_W     = 14,
  parameter int unsigned DLY_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [POS_W-1:0] pos_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             synced_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o    <= '0;
      dly_o    <= '0;
      synced_o <= 1'b0;
    end else if (frame_i) begin
      pos_o    <= '0;
      dly_o    <= delay_i;
      synced_o <= 1'b1;
    end else begin
      pos_o <= (pos_o == LAST_POS) ? '0 : pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_sample_point.sv
module tdm_sample_point #(
  parameter int unsigned CLK_PER_BIT = 16,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned FRAME_LEN   = 16384,
  parameter int unsigned POS_W       = 14,
  parameter int unsigned DLY_W       = 5,
  parameter int unsigned CH_W        = 7
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             smp_o,
  output logic             last_o,
  output logic [CH_W-1:0]  ch_o
);
  localparam int unsigned CPB_W  = $clog2(CLK_PER_BIT);
  localparam int unsigned BPOS_W = $clog2(BITS_PER_CH);
  localparam int unsigned QSTEP  = CLK_PER_BIT / 4;
  localparam int unsigned BASE   = (CLK_PER_BIT * 3) / 4;

  logic [POS_W:0] off, pos_x, sp;

  always_comb begin
    off   = (POS_W+1)'(BASE) + (POS_W+1)'(dly_i) * (POS_W+1)'(QSTEP);
    pos_x = {1'b0, pos_i};
    // position relative to the delayed frame start, wrapped into the previous frame
    sp    = (pos_x >= off) ? (pos_x - off) : (pos_x + (POS_W+1)'(FRAME_LEN) - off);
  end

  assign smp_o  = (sp[CPB_W-1:0] == '0);
  assign last_o = &sp[CPB_W+BPOS_W-1:CPB_W];
  assign ch_o   = sp[POS_W-1:CPB_W+BPOS_W];
endmodule

// File: rtl/tdm_byte_packer.sv
module tdm_byte_packer #(
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned CH_W        = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   last_i,
  input  logic [CH_W-1:0]        ch_i,
  input  logic                   ser_i,
  output logic [BITS_PER_CH-1:0] byte_o,
  output logic [CH_W-1:0]        chan_o,
  output logic                   valid_o
);
  logic [BITS_PER_CH-1:0] sh_q, sh_d;

  assign sh_d = {sh_q[BITS_PER_CH-2:0], ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i & last_i;
      if (en_i) sh_q <= sh_d;
      if (en_i && last_i) begin
        byte_o <= sh_d;
        chan_o <= ch_i;
      end
    end
  end
endmodule

// File: rtl/tdm_frac_delay_rx.sv
module tdm_frac_delay_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned CPB   = CLK_PER_BIT,
  parameter int unsigned BPC   = BITS_PER_CH,
  parameter int unsigned NCH   = NUM_CH,
  parameter int unsigned DW    = DLY_W,
  localparam int unsigned FRAME_LEN = CPB * BPC * NCH,
  localparam int unsigned POS_W     = $clog2(FRAME_LEN),
  localparam int unsigned CH_W      = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic            ser_i,
  input  logic [DW-1:0]   delay_i,
  output logic [BPC-1:0]  byte_o,
  output logic [CH_W-1:0] chan_o,
  output logic            valid_o
);
  logic [POS_W-1:0] pos;
  logic [DW-1:0]    act_dly;
  logic             synced, smp, last;
  logic [CH_W-1:0]  ch;

  tdm_frame_timer #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W), .DLY_W(DW)) u_timer (
    .clk_i, .rst_ni, .frame_i, .delay_i,
    .pos_o(pos), .dly_o(act_dly), .synced_o(synced)
  );

  tdm_sample_point #(
    .CLK_PER_BIT(CPB), .BITS_PER_CH(BPC), .FRAME_LEN(FRAME_LEN),
    .POS_W(POS_W), .DLY_W(DW), .CH_W(CH_W)
  ) u_smp (
    .pos_i(pos), .dly_i(act_dly), .smp_o(smp), .last_o(last), .ch_o(ch)
  );

  tdm_byte_packer #(.BITS_PER_CH(BPC), .CH_W(CH_W)) u_pack (
    .clk_i, .rst_ni, .en_i(synced & smp), .last_i(last), .ch_i(ch), .ser_i,
    .byte_o, .chan_o, .valid_o
  );
endmodule

// File: rtl/tdm_frac_delay_rx_chk.sv
module tdm_frac_delay_rx_chk #(
  parameter int unsigned DW   = 5,
  parameter int unsigned CH_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_i,
  input logic [DW-1:0]   delay_i,
  input logic [DW-1:0]   act_dly,
  input logic [CH_W-1:0] chan_o,
  input logic            valid_o
);
  logic seen_fp;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_fp <= 1'b0;
    else if (frame_i) seen_fp <= 1'b1;
  end

  // R2
  no_valid_before_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fp |-> !valid_o);
  // R7
  valid_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(chan_o));
  // R9
  dly_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> $stable(act_dly));
  // R9
  dly_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_i) |-> act_dly == $past(delay_i));
endmodule

bind tdm_frac_delay_rx tdm_frac_delay_rx_chk #(.DW(DW), .CH_W(CH_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .delay_i(delay_i),
  .act_dly(act_dly), .chan_o(chan_o), .valid_o(valid_o)
);

// File: tb/test_tdm_frac_delay_rx.sv
module test_tdm_frac_delay_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 16384;
  localparam int NFRAMES = 9;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       ser_i = 1'b0;
  logic [4:0] delay_i = '0;
  logic [7:0] byte_o;
  logic [6:0] chan_o;
  logic       valid_o;

  tdm_frac_delay_rx i_tdm_frac_delay_rx (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  int tb_pos = 0, fcnt = -1, line_d = 0, gen_cnt = 0, last_ch = 0, pre_valids = 0;
  bit started = 0, skip127 = 0, run_fr = 0, have_last = 0, prev_v = 0, done = 0;
  logic [31:0] salt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic data_bit(input int f, input int b);
    logic [31:0] h;
    h = (32'(f) * 32'd1031 + 32'(b)) * 32'h9E3779B1;
    h = h ^ salt;
    h = h ^ (h >> 15);
    return h[7];
  endfunction

  function automatic logic line_bit(input int p);
    int t;
    t = p - 4 * line_d;
    if (t >= 0) return data_bit(fcnt, t / 16);
    return data_bit(fcnt - 1, (t + FRAME) / 16);
  endfunction

  always @(posedge clk_i) begin
    if (frame_i) begin
      tb_pos  <= 0;
      fcnt    <= fcnt + 1;
      line_d  <= int'(delay_i);
      skip127 <= (int'(delay_i) != line_d) || !started;
      started <= 1'b1;
    end else begin
      tb_pos <= (tb_pos + 1) % FRAME;
    end
  end

  always @(negedge clk_i) begin
    if (run_fr) begin
      frame_i = (gen_cnt == 0);
      gen_cnt = (gen_cnt + 1) % FRAME;
    end
    ser_i = started ? line_bit(tb_pos) : 1'($urandom % 2);
    if (rst_ni && !started && valid_o) pre_valids++;
    if (valid_o && started) begin
      int ch, f, ep;
      logic [7:0] eb;
      ch = int'(chan_o);
      f  = (ch == 127 && tb_pos < FRAME / 2) ? fcnt - 1 : fcnt;
      chk(!prev_v, "R7 valid width", 1, 0);
      if (!(skip127 && ch == 127 && f != fcnt)) begin
        for (int i = 0; i < 8; i++) eb[7-i] = data_bit(f, 8 * ch + i);
        ep = (16 * (8 * ch + 7) + 12 + 4 * line_d + 1) % FRAME;
        if (f != fcnt) begin
          // R8 straddling channel 127
          chk(byte_o == eb, "R8 straddle byte", int'(byte_o), int'(eb));
          chk(tb_pos == ep, "R8 straddle timing", tb_pos, ep);
        end else begin
          // R5 byte content, R3/R4/R9 strobe timing
          chk(byte_o == eb, "R5 byte", int'(byte_o), int'(eb));
          chk(tb_pos == ep, (line_d == 0) ? "R3 timing" : "R4/R9 timing", tb_pos, ep);
        end
      end
      if (have_last && !(skip127 && (ch == 0 || ch == 127)))
        chk(ch == (last_ch + 1) % 128, "R6 channel order", ch, (last_ch + 1) % 128);
      have_last = 1'b1;
      last_ch = ch;
    end
    prev_v = valid_o;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int dl [NFRAMES];
    void'($urandom(32'd4711));
    salt = $urandom;
    dl = '{1, 31, 31, 4, 30, 8, 0, 0, 0};
    dl[6] = int'($urandom % 32);
    dl[7] = int'($urandom % 32);
    repeat (3) @(negedge clk_i);
    // R1
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(byte_o == 8'h00, "R1 byte in reset", int'(byte_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(chan_o == 7'd0, "R1 chan after reset", int'(chan_o), 0);
    chk(valid_o == 1'b0, "R1 valid after reset", int'(valid_o), 0);
    repeat (400) @(negedge clk_i);
    chk(pre_valids == 0, "R2 no strobe before frame pulse", pre_valids, 0);
    run_fr = 1'b1;
    for (int k = 0; k < NFRAMES; k++) begin
      @(posedge clk_i iff frame_i);
      repeat (20) @(negedge clk_i);
      delay_i = 5'(dl[k]);  // R9: change mid-frame, before channel 0 is sampled
    end
    @(posedge clk_i iff frame_i);
    repeat (400) @(negedge clk_i);
    finish_run();
  end
endmodule